// File: doc/BRIEF.md
# Branch and Bit-Test Branch Unit

This unit resolves the control-transfer instructions of a small 8-bit processor. It covers three kinds of jump: to an absolute address, to a relative address, and to the address held in the A:X register pair. It also covers four branches that test a flag, branches that test a single bit, and decrement-and-branch loops on B, C or a memory byte. The decoder presents an opcode together with the operands it has already fetched: the current PC, a signed displacement, an absolute target, the A, X, B and C registers, the carry and zero flags, one operand byte and a bit index. The unit works out the next PC and whether the branch was taken. It also produces the decremented byte and a write strobe that says where that byte goes.

Each instruction keeps the unit busy for a fixed number of clocks. This count and the base of the relative target both depend on the length of the instruction's encoding. When the count runs out, a single-cycle done pulse is raised and all results are valid. The results then stay on the outputs until the next instruction is accepted. A start request made while busy is dropped, and so is a start with an unassigned opcode.

Top module: `brx_unit`

## Requirements
- R1: While reset is held and right after it, `busy`, `done`, `taken`, the three write strobes and `pc_out` are all 0.
- R2: Opcode codes and their cycle counts are: 0 absolute jump (6), 1 relative jump (6), 2 jump to A:X (6), 3 branch if CY=1 (6), 4 branch if CY=0 (6), 5 branch if Z=1 (6), 6 branch if Z=0 (6), 7 long bit-set branch (10), 8 long bit-clear branch (10), 9 branch if A bit set (8), 10 branch if A bit clear (8), 11 decrement B and branch (6), 12 decrement C and branch (6), 13 decrement memory byte and branch (8). `done` rises N-1 clock edges after the edge that accepts `start`.
- R3: Opcode 0 loads `abs_tgt` into the PC. Opcode 1 loads PC+2+disp. Opcode 2 loads {A,X}. All three are always taken.
- R4: Opcodes 3 to 6 are 2-byte instructions. When the flag condition holds they go to PC+2+disp; otherwise they go to PC+2.
- R5: Opcodes 7 and 8 are 4-byte instructions. They test bit `bit_idx` of `opnd` and go to PC+4+disp when the bit is 1 (opcode 7) or 0 (opcode 8); otherwise they go to PC+4.
- R6: Opcodes 9 and 10 are 3-byte instructions. They test bit `bit_idx` of `reg_a` and go to PC+3+disp when the bit is 1 (opcode 9) or 0 (opcode 10); otherwise they go to PC+3.
- R7: Opcodes 11 and 12 are 2-byte instructions. They output B-1 or C-1 on `wr_data` with `wr_b` or `wr_c`, and go to PC+2+disp when the decremented value is nonzero; otherwise they go to PC+2.
- R8: Opcode 13 is a 3-byte instruction. It outputs `opnd`-1 with `wr_mem` and goes to PC+3+disp when that value is nonzero; otherwise it goes to PC+3.
- R9: Decrementing 00h gives FFh, which counts as nonzero, so the branch is taken.
- R10: `disp` is sign-extended from 8 bits before it is added. Address arithmetic wraps modulo 2^16.
- R11: A `start` request made while `busy` is 1 has no effect, and neither does a `start` with opcode 14 or 15.
- R12: `done` and the write strobes are high for exactly one cycle. `pc_out`, `taken` and `wr_data` stay stable until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an instruction when idle |
| op | input | 4 | Opcode (see R2) |
| pc_in | input | 16 | Address of the instruction |
| disp | input | 8 | Signed relative displacement |
| abs_tgt | input | 16 | Absolute jump target |
| reg_a | input | 8 | A register |
| reg_x | input | 8 | X register |
| flag_cy | input | 1 | Carry flag |
| flag_z | input | 1 | Zero flag |
| opnd | input | 8 | Fetched memory, special-register or PSW byte |
| bit_idx | input | 3 | Bit index for the bit-test forms |
| reg_b | input | 8 | B register |
| reg_c | input | 8 | C register |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle completion pulse |
| taken | output | 1 | Branch condition held |
| pc_out | output | 16 | Next PC |
| wr_b | output | 1 | Write `wr_data` to B (with done) |
| wr_c | output | 1 | Write `wr_data` to C (with done) |
| wr_mem | output | 1 | Write `wr_data` to memory (with done) |
| wr_data | output | 8 | Decremented byte |

## Verification
Each opcode is run with its condition both true and false, so a swapped sense or a swapped flag shows up as a wrong `taken` and a wrong PC. The relative forms are given displacements near the top of the address space as well as negative ones. These tell the different instruction lengths used as the target base apart, check the sign extension, and check the 16-bit wrap. The decrement forms use starting values 05h, 01h and 00h, which separate the taken case, the not-taken case and the wrap. The long and accumulator bit tests set one bit and test both that bit and a neighbour, which catches a wrong bit or a wrong source byte. Directed cases cover a restart attempted while busy and unassigned opcodes.

// File: rtl/brx_pkg.sv
package brx_pkg;

    parameter int BRX_AW    = 16;
    parameter int BRX_DW    = 8;
    parameter int BRX_OP_W  = 4;
    parameter int BRX_CNT_W = 4;

    typedef enum logic [BRX_OP_W-1:0] {
        OP_JMP_ABS = 4'd0,
        OP_JMP_REL = 4'd1,
        OP_JMP_AX  = 4'd2,
        OP_BR_CY   = 4'd3,
        OP_BR_NCY  = 4'd4,
        OP_BR_Z    = 4'd5,
        OP_BR_NZ   = 4'd6,
        OP_BT_LONG = 4'd7,
        OP_BF_LONG = 4'd8,
        OP_BT_ACC  = 4'd9,
        OP_BF_ACC  = 4'd10,
        OP_DJ_B    = 4'd11,
        OP_DJ_C    = 4'd12,
        OP_DJ_MEM  = 4'd13
    } brx_op_e;

    typedef enum logic [2:0] {
        CL_NONE,
        CL_ABS,
        CL_REL,
        CL_AX,
        CL_FLAG,
        CL_BIT_LONG,
        CL_BIT_ACC,
        CL_DEC
    } brx_cls_e;

    typedef enum logic [1:0] {
        DS_NONE,
        DS_B,
        DS_C,
        DS_MEM
    } brx_dsrc_e;

endpackage

// File: rtl/brx_decode.sv
module brx_decode
    import brx_pkg::*;
#(
    parameter int OP_W  = BRX_OP_W,
    parameter int CNT_W = BRX_CNT_W
) (
    input  logic [OP_W-1:0]  op,
    output logic             valid,
    output brx_cls_e         cls,
    output logic [2:0]       len,
    output logic [CNT_W-1:0] cycles,
    output logic             use_z,
    output logic             want_one,
    output brx_dsrc_e        dsrc
);

    localparam logic [CNT_W-1:0] CYC_SHORT = CNT_W'(6);
    localparam logic [CNT_W-1:0] CYC_MID   = CNT_W'(8);
    localparam logic [CNT_W-1:0] CYC_LONG  = CNT_W'(10);

    always_comb begin
        valid    = 1'b1;
        cls      = CL_NONE;
        len      = 3'd2;
        cycles   = CYC_SHORT;
        use_z    = 1'b0;
        want_one = 1'b1;
        dsrc     = DS_NONE;
        case (op)
            OP_JMP_ABS: begin cls = CL_ABS; len = 3'd3; end
            OP_JMP_REL: begin cls = CL_REL; end
            OP_JMP_AX:  begin cls = CL_AX;  len = 3'd1; end
            OP_BR_CY:   begin cls = CL_FLAG; end
            OP_BR_NCY:  begin cls = CL_FLAG; want_one = 1'b0; end
            OP_BR_Z:    begin cls = CL_FLAG; use_z = 1'b1; end
            OP_BR_NZ:   begin cls = CL_FLAG; use_z = 1'b1; want_one = 1'b0; end
            OP_BT_LONG: begin cls = CL_BIT_LONG; len = 3'd4; cycles = CYC_LONG; end
            OP_BF_LONG: begin
                cls = CL_BIT_LONG; len = 3'd4; cycles = CYC_LONG; want_one = 1'b0;
            end
            OP_BT_ACC:  begin cls = CL_BIT_ACC; len = 3'd3; cycles = CYC_MID; end
            OP_BF_ACC:  begin
                cls = CL_BIT_ACC; len = 3'd3; cycles = CYC_MID; want_one = 1'b0;
            end
            OP_DJ_B:    begin cls = CL_DEC; dsrc = DS_B; end
            OP_DJ_C:    begin cls = CL_DEC; dsrc = DS_C; end
            OP_DJ_MEM:  begin cls = CL_DEC; dsrc = DS_MEM; len = 3'd3; cycles = CYC_MID; end
            default:    valid = 1'b0;
        endcase
    end

endmodule

// File: rtl/brx_cond.sv
module brx_cond
    import brx_pkg::*;
#(
    parameter int DW = BRX_DW,
    localparam int BW = $clog2(DW)
) (
    input  brx_cls_e        cls,
    input  logic            use_z,
    input  logic            want_one,
    input  brx_dsrc_e       dsrc,
    input  logic            flag_cy,
    input  logic            flag_z,
    input  logic [DW-1:0]   opnd,
    input  logic [DW-1:0]   reg_a,
    input  logic [BW-1:0]   bit_idx,
    input  logic [DW-1:0]   reg_b,
    input  logic [DW-1:0]   reg_c,
    output logic            taken,
    output logic [DW-1:0]   dec_val,
    output logic [2:0]      wr_sel
);

    logic [DW-1:0] dec_src;
    logic          probe;

    always_comb begin
        case (dsrc)
            DS_B:    dec_src = reg_b;
            DS_C:    dec_src = reg_c;
            default: dec_src = opnd;
        endcase
        dec_val = dec_src - DW'(1);

        wr_sel = 3'b000;
        case (dsrc)
            DS_B:    wr_sel = 3'b100;
            DS_C:    wr_sel = 3'b010;
            DS_MEM:  wr_sel = 3'b001;
            default: wr_sel = 3'b000;
        endcase

        case (cls)
            CL_FLAG:     probe = use_z ? flag_z : flag_cy;
            CL_BIT_LONG: probe = opnd[bit_idx];
            CL_BIT_ACC:  probe = reg_a[bit_idx];
            default:     probe = 1'b0;
        endcase

        case (cls)
            CL_ABS, CL_REL, CL_AX:            taken = 1'b1;
            CL_FLAG, CL_BIT_LONG, CL_BIT_ACC: taken = (probe == want_one);
            CL_DEC:                           taken = |dec_val;
            default:                          taken = 1'b0;
        endcase
    end

endmodule

// File: rtl/brx_target.sv
module brx_target
    import brx_pkg::*;
#(
    parameter int AW = BRX_AW,
    parameter int DW = BRX_DW
) (
    input  brx_cls_e       cls,
    input  logic           taken,
    input  logic [AW-1:0]  pc_in,
    input  logic [2:0]     len,
    input  logic [DW-1:0]  disp,
    input  logic [AW-1:0]  abs_tgt,
    input  logic [DW-1:0]  reg_a,
    input  logic [DW-1:0]  reg_x,
    output logic [AW-1:0]  pc_nxt
);

    localparam int PAIR_W = 2 * DW;

    logic [AW-1:0] fall_pc;
    logic [AW-1:0] rel_pc;
    logic [AW-1:0] pair_pc;
    logic [AW-1:0] disp_ext;

    assign disp_ext = {{(AW-DW){disp[DW-1]}}, disp};
    assign fall_pc  = pc_in + AW'(len);
    assign rel_pc   = fall_pc + disp_ext;

    generate
        if (AW == PAIR_W) begin : g_pair_exact
            assign pair_pc = {reg_a, reg_x};
        end else if (AW > PAIR_W) begin : g_pair_pad
            assign pair_pc = {{(AW-PAIR_W){1'b0}}, reg_a, reg_x};
        end else begin : g_pair_trim
            logic [PAIR_W-1:0] pair_full;
            assign pair_full = {reg_a, reg_x};
            assign pair_pc   = pair_full[AW-1:0];
        end
    endgenerate

    always_comb begin
        case (cls)
            CL_ABS:  pc_nxt = abs_tgt;
            CL_AX:   pc_nxt = pair_pc;
            default: pc_nxt = taken ? rel_pc : fall_pc;
        endcase
    end

endmodule

// File: rtl/brx_unit.sv
module brx_unit
    import brx_pkg::*;
#(
    parameter int AW    = BRX_AW,
    parameter int DW    = BRX_DW,
    parameter int OP_W  = BRX_OP_W,
    parameter int CNT_W = BRX_CNT_W,
    localparam int BW   = $clog2(DW)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [OP_W-1:0]  op,
    input  logic [AW-1:0]    pc_in,
    input  logic [DW-1:0]    disp,
    input  logic [AW-1:0]    abs_tgt,
    input  logic [DW-1:0]    reg_a,
    input  logic [DW-1:0]    reg_x,
    input  logic             flag_cy,
    input  logic             flag_z,
    input  logic [DW-1:0]    opnd,
    input  logic [BW-1:0]    bit_idx,
    input  logic [DW-1:0]    reg_b,
    input  logic [DW-1:0]    reg_c,
    output logic             busy,
    output logic             done,
    output logic             taken,
    output logic [AW-1:0]    pc_out,
    output logic             wr_b,
    output logic             wr_c,
    output logic             wr_mem,
    output logic [DW-1:0]    wr_data
);

    typedef struct packed {
        logic             busy;
        logic             done;
        logic [CNT_W-1:0] cnt;
        logic             taken;
        logic [AW-1:0]    pc;
        logic [2:0]       wsel;
        logic [DW-1:0]    data;
    } brx_state_t;

    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(1);

    brx_state_t st_d, st_q;

    logic             dec_valid;
    brx_cls_e         dec_cls;
    logic [2:0]       dec_len;
    logic [CNT_W-1:0] dec_cycles;
    logic             dec_use_z;
    logic             dec_want_one;
    brx_dsrc_e        dec_dsrc;
    logic             cond_taken;
    logic [DW-1:0]    cond_dec_val;
    logic [2:0]       cond_wr_sel;
    logic [AW-1:0]    tgt_pc;

    brx_decode #(.OP_W(OP_W), .CNT_W(CNT_W)) u_decode (
        .op       (op),
        .valid    (dec_valid),
        .cls      (dec_cls),
        .len      (dec_len),
        .cycles   (dec_cycles),
        .use_z    (dec_use_z),
        .want_one (dec_want_one),
        .dsrc     (dec_dsrc)
    );

    brx_cond #(.DW(DW)) u_cond (
        .cls      (dec_cls),
        .use_z    (dec_use_z),
        .want_one (dec_want_one),
        .dsrc     (dec_dsrc),
        .flag_cy  (flag_cy),
        .flag_z   (flag_z),
        .opnd     (opnd),
        .reg_a    (reg_a),
        .bit_idx  (bit_idx),
        .reg_b    (reg_b),
        .reg_c    (reg_c),
        .taken    (cond_taken),
        .dec_val  (cond_dec_val),
        .wr_sel   (cond_wr_sel)
    );

    brx_target #(.AW(AW), .DW(DW)) u_target (
        .cls      (dec_cls),
        .taken    (cond_taken),
        .pc_in    (pc_in),
        .len      (dec_len),
        .disp     (disp),
        .abs_tgt  (abs_tgt),
        .reg_a    (reg_a),
        .reg_x    (reg_x),
        .pc_nxt   (tgt_pc)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (st_q.busy) begin
            if (st_q.cnt == CNT_LAST) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt - CNT_W'(1);
            end
        end else if (start && dec_valid) begin
            st_d.busy  = 1'b1;
            st_d.cnt   = dec_cycles - CNT_W'(1);
            st_d.taken = cond_taken;
            st_d.pc    = tgt_pc;
            st_d.wsel  = cond_wr_sel;
            st_d.data  = (dec_cls == CL_DEC) ? cond_dec_val : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy    = st_q.busy;
    assign done    = st_q.done;
    assign taken   = st_q.taken;
    assign pc_out  = st_q.pc;
    assign wr_b    = st_q.done & st_q.wsel[2];
    assign wr_c    = st_q.done & st_q.wsel[1];
    assign wr_mem  = st_q.done & st_q.wsel[0];
    assign wr_data = st_q.data;

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R12

    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy)); // R2

    AST_HOLD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(pc_out) && $stable(taken) && $stable(wr_data))); // R11

    AST_ONE_WRITER: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_b, wr_c, wr_mem})); // R7

    AST_DEC_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_b || wr_c || wr_mem) |-> (taken == (wr_data != '0))); // R9

endmodule

// File: tb/sim_brx_unit.sv
module sim_brx_unit;

    typedef struct packed {
        logic [3:0]  op;
        logic [15:0] pc;
        logic [7:0]  disp;
        logic        cy;
        logic        z;
        logic [7:0]  opnd;
        logic [2:0]  bsel;
        logic [7:0]  a;
        logic [7:0]  b;
        logic [7:0]  c;
        logic [15:0] epc;
        logic        etk;
        logic [3:0]  ecyc;
        logic [2:0]  ewe;
        logic [7:0]  eval;
    } vec_t;

    localparam int NV = 18;
    localparam logic [15:0] TGT = 16'h4321;
    localparam logic [7:0]  XV  = 8'h5A;

    localparam vec_t VT [NV] = '{
        '{4'd0,  16'h1000, 8'h00, 1'b0, 1'b0, 8'h00, 3'd0, 8'h00, 8'h00, 8'h00, 16'h4321, 1'b1, 4'd6,  3'b000, 8'h00},
        '{4'd1,  16'h1000, 8'h10, 1'b0, 1'b0, 8'h00, 3'd0, 8'h00, 8'h00, 8'h00, 16'h1012, 1'b1, 4'd6,  3'b000, 8'h00},
        '{4'd2,  16'h1000, 8'h00, 1'b0, 1'b0, 8'h00, 3'd0, 8'h12, 8'h00, 8'h00, 16'h125A, 1'b1, 4'd6,  3'b000, 8'h00},
        '{4'd3,  16'h2000, 8'h05, 1'b1, 1'b0, 8'h00, 3'd0, 8'h00, 8'h00, 8'h00, 16'h2007, 1'b1, 4'd6,  3'b000, 8'h00},
        '{4'd3,  16'h2000, 8'h05, 1'b0, 1'b1, 8'h00, 3'd0, 8'h00, 8'h00, 8'h00, 16'h2002, 1'b0, 4'd6,  3'b000, 8'h00},
        '{4'd4,  16'h2000, 8'h05, 1'b0, 1'b0, 8'h00, 3'd0, 8'h00, 8'h00, 8'h00, 16'h2007, 1'b1, 4'd6,  3'b000, 8'h00},
        '{4'd5,  16'h2000, 8'hF0, 1'b0, 1'b1, 8'h00, 3'd0, 8'h00, 8'h00, 8'h00, 16'h1FF2, 1'b1, 4'd6,  3'b000, 8'h00},
        '{4'd6,  16'h2000, 8'hF0, 1'b1, 1'b1, 8'h00, 3'd0, 8'h00, 8'h00, 8'h00, 16'h2002, 1'b0, 4'd6,  3'b000, 8'h00},
        '{4'd7,  16'h3000, 8'h20, 1'b0, 1'b0, 8'h08, 3'd3, 8'h00, 8'h00, 8'h00, 16'h3024, 1'b1, 4'd10, 3'b000, 8'h00},
        '{4'd8,  16'h3000, 8'h20, 1'b0, 1'b0, 8'h08, 3'd3, 8'hF7, 8'h00, 8'h00, 16'h3004, 1'b0, 4'd10, 3'b000, 8'h00},
        '{4'd9,  16'h3000, 8'h20, 1'b0, 1'b0, 8'h00, 3'd7, 8'h80, 8'h00, 8'h00, 16'h3023, 1'b1, 4'd8,  3'b000, 8'h00},
        '{4'd10, 16'h3000, 8'h20, 1'b0, 1'b0, 8'hFF, 3'd6, 8'h80, 8'h00, 8'h00, 16'h3023, 1'b1, 4'd8,  3'b000, 8'h00},
        '{4'd11, 16'h4000, 8'hFE, 1'b0, 1'b0, 8'h00, 3'd0, 8'h00, 8'h05, 8'h09, 16'h4000, 1'b1, 4'd6,  3'b100, 8'h04},
        '{4'd11, 16'h4000, 8'hFE, 1'b0, 1'b0, 8'h00, 3'd0, 8'h00, 8'h01, 8'h09, 16'h4002, 1'b0, 4'd6,  3'b100, 8'h00},
        '{4'd12, 16'h4000, 8'h10, 1'b0, 1'b0, 8'h00, 3'd0, 8'h00, 8'h05, 8'h00, 16'h4012, 1'b1, 4'd6,  3'b010, 8'hFF},
        '{4'd13, 16'h4000, 8'h10, 1'b0, 1'b0, 8'h03, 3'd0, 8'h00, 8'h00, 8'h00, 16'h4013, 1'b1, 4'd8,  3'b001, 8'h02},
        '{4'd13, 16'h4000, 8'h10, 1'b0, 1'b0, 8'h01, 3'd0, 8'h00, 8'h00, 8'h00, 16'h4003, 1'b0, 4'd8,  3'b001, 8'h00},
        '{4'd1,  16'hFFF0, 8'h20, 1'b0, 1'b0, 8'h00, 3'd0, 8'h00, 8'h00, 8'h00, 16'h0012, 1'b1, 4'd6,  3'b000, 8'h00}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  op = '0;
    logic [15:0] pc_in = '0;
    logic [7:0]  disp = '0;
    logic [15:0] abs_tgt = TGT;
    logic [7:0]  reg_a = '0;
    logic [7:0]  reg_x = XV;
    logic        flag_cy = 1'b0;
    logic        flag_z = 1'b0;
    logic [7:0]  opnd = '0;
    logic [2:0]  bit_idx = '0;
    logic [7:0]  reg_b = '0;
    logic [7:0]  reg_c = '0;
    logic        busy, done, taken, wr_b, wr_c, wr_mem;
    logic [15:0] pc_out;
    logic [7:0]  wr_data;

    int total = 0;
    int bad = 0;
    int cyc_count = 0;

    always #2 clk = ~clk;

    brx_unit u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .pc_in(pc_in),
        .disp(disp), .abs_tgt(abs_tgt), .reg_a(reg_a), .reg_x(reg_x),
        .flag_cy(flag_cy), .flag_z(flag_z), .opnd(opnd), .bit_idx(bit_idx),
        .reg_b(reg_b), .reg_c(reg_c), .busy(busy), .done(done), .taken(taken),
        .pc_out(pc_out), .wr_b(wr_b), .wr_c(wr_c), .wr_mem(wr_mem), .wr_data(wr_data)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic string req_of(input logic [3:0] o);
        case (o)
            4'd0, 4'd1, 4'd2:        return "R3";
            4'd3, 4'd4, 4'd5, 4'd6:  return "R4";
            4'd7, 4'd8:              return "R5";
            4'd9, 4'd10:             return "R6";
            4'd11, 4'd12:            return "R7";
            default:                 return "R8";
        endcase
    endfunction

    task automatic apply(input vec_t v);
        op = v.op; pc_in = v.pc; disp = v.disp; flag_cy = v.cy; flag_z = v.z;
        opnd = v.opnd; bit_idx = v.bsel; reg_a = v.a; reg_b = v.b; reg_c = v.c;
    endtask

    task automatic wait_done(output int n);
        n = 1;
        while (!done && n < 20) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin : watchdog
        while (cyc_count < 100000) begin
            @(posedge clk);
            cyc_count++;
        end
        bad++;
        total++;
        $display("FAIL watchdog expired actual=%0d expected=finish", cyc_count);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        int n;
        logic [15:0] held;
        repeat (3) @(negedge clk);
        // R1 reset values
        chk("R1", "busy", busy, 0);
        chk("R1", "done", done, 0);
        chk("R1", "pc_out", pc_out, 0);
        chk("R1", "taken", taken, 0);
        chk("R1", "strobes", {wr_b, wr_c, wr_mem}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "done after release", done, 0);

        // table walk: R2 cycle counts, R3..R10 results
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            apply(VT[i]);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            wait_done(n);
            chk("R2", $sformatf("cycles v%0d", i), n, VT[i].ecyc);
            chk(req_of(VT[i].op), $sformatf("pc v%0d", i), pc_out, VT[i].epc);
            chk(req_of(VT[i].op), $sformatf("taken v%0d", i), taken, VT[i].etk);
            chk(req_of(VT[i].op), $sformatf("strobes v%0d", i),
                {wr_b, wr_c, wr_mem}, VT[i].ewe);
            if (VT[i].ewe != 3'b000)
                chk(req_of(VT[i].op), $sformatf("data v%0d", i), wr_data, VT[i].eval);
        end

        // R12 one-cycle done, results held
        held = pc_out;
        @(negedge clk);
        chk("R12", "done drops", done, 0);
        chk("R12", "strobes drop", {wr_b, wr_c, wr_mem}, 0);
        repeat (3) @(negedge clk);
        chk("R12", "pc held", pc_out, held);

        // R11 start while busy is dropped
        apply('{4'd7, 16'h5000, 8'h00, 1'b0, 1'b0, 8'hFF, 3'd0, 8'h00, 8'h00, 8'h00,
                16'h0, 1'b0, 4'd0, 3'b000, 8'h00});
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (2) @(negedge clk);
        op = 4'd0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 4;
        while (!done && n < 20) begin
            @(negedge clk);
            n++;
        end
        chk("R11", "cycles with restart attempt", n, 10);
        chk("R11", "pc with restart attempt", pc_out, 16'h5004);
        n = 0;
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            if (done) n++;
        end
        chk("R11", "no second done", n, 0);

        // R11 unassigned opcodes dropped
        for (int u = 14; u < 16; u++) begin
            op = 4'(u);
            pc_in = 16'h7777;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            n = 0;
            for (int k = 0; k < 12; k++) begin
                if (done || busy) n++;
                @(negedge clk);
            end
            chk("R11", $sformatf("opcode %0d activity", u), n, 0);
            chk("R11", $sformatf("opcode %0d pc", u), pc_out, 16'h5004);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule